// File: doc/BRIEF.md
# Sign-Magnitude Adder/Subtractor

This block adds or subtracts two numbers kept in sign-magnitude form. Each operand has a sign bit and an unsigned magnitude of `MAG_W` bits. A request is made by pulsing `start` with the operands and the operation. The unit captures them and decides from the two signs and the operation whether the magnitudes are summed or differenced. It then runs the selected step on one shared adder.

When a difference wraps, the unit recovers the true magnitude in two more steps, a bitwise inversion and then an increment, and it flips the result sign. A difference of zero is always returned as positive. A carry out of a magnitude sum raises the overflow flag, and the flag is cleared on every difference.

The result and the flag stay on the outputs from the one-cycle `done` pulse until the next accepted request. Requests that arrive while an operation is in progress are dropped.

Top module: `sm_addsub`

## Requirements
- R1: After reset, `res_sign`, `res_mag`, `ovf` and `done` are all 0.
- R2: The encodings are: `op`=0 selects add and `op`=1 selects subtract; a sign bit of 1 means negative. An add with equal signs, or a subtract with unequal signs, takes the sum path. The sum path returns the low `MAG_W` bits of `a_mag + b_mag` with `res_sign` equal to `a_sign`.
- R3: On the sum path, `ovf` equals the carry out of the `MAG_W`-bit magnitude sum.
- R4: Every other case takes the difference path. It returns `|a_mag - b_mag|` with `ovf` = 0.
- R5: On the difference path, the sign depends on the magnitudes. If `a_mag > b_mag`, `res_sign` equals `a_sign`. If `a_mag < b_mag`, `res_sign` is the inverse of `a_sign`. If the magnitudes are equal, `res_sign` is 0.
- R6: `done` is high for exactly one cycle per accepted request. Count from the clock edge that samples `start`. `done` appears 4 edges later for a sum, or for a difference with `a_mag >= b_mag`. It appears 5 edges later for a difference with `a_mag < b_mag`.
- R7: A `start` seen while an operation is in progress is ignored. The running operation completes on its captured operands, and no second `done` follows.
- R8: `res_sign`, `res_mag` and `ovf` keep their values after `done` until a new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted only when idle |
| op | input | 1 | 0 = add, 1 = subtract |
| a_sign | input | 1 | Sign of first operand (1 = negative) |
| a_mag | input | MAG_W | Magnitude of first operand |
| b_sign | input | 1 | Sign of second operand (1 = negative) |
| b_mag | input | MAG_W | Magnitude of second operand |
| done | output | 1 | One-cycle completion pulse |
| res_sign | output | 1 | Result sign |
| res_mag | output | MAG_W | Result magnitude |
| ovf | output | 1 | Magnitude sum overflowed |

## Verification
Directed cases cover all four sign combinations under both operations, so each one reaches the path that R2 and R4 assign to it.

- Difference cases are split into larger, smaller and equal magnitudes. This separates the no-correction exit, the invert-and-increment exit with its extra cycle, and the forced positive zero.
- Sum cases that do and do not carry out of the top bit separate the flag's two values.
- A long stream of pseudo-random operands, with negative zeros and extreme magnitudes mixed in, is compared against an integer model of the rules.
- A second request is issued in the middle of an operation to show that it is dropped.

// File: rtl/sm_addsub_pkg.sv
package sm_addsub_pkg;

   localparam logic OP_ADD = 1'b0;
   localparam logic OP_SUB = 1'b1;

   typedef enum logic [2:0] {
      ST_IDLE    = 3'd0,
      ST_COMPARE = 3'd1,
      ST_ARITH   = 3'd2,
      ST_CHECK   = 3'd3,
      ST_INCR    = 3'd4,
      ST_DONE    = 3'd5
   } seq_state_e;

   typedef enum logic [1:0] {
      ALU_SUM  = 2'd0,
      ALU_DIFF = 2'd1,
      ALU_INV  = 2'd2,
      ALU_INC  = 2'd3
   } alu_mode_e;

endpackage

// File: rtl/sm_sign_cmp.sv
module sm_sign_cmp (
   input  logic op,
   input  logic sign_x,
   input  logic sign_y,
   output logic take_diff
);
   logic signs_differ;

   always_comb begin
      signs_differ = sign_x ^ sign_y;
      // sum path when (add, same signs) or (sub, different signs)
      take_diff    = signs_differ ^ op;
   end
endmodule

// File: rtl/sm_mag_alu.sv
module sm_mag_alu
   import sm_addsub_pkg::*;
#(
   parameter int  MAG_W  = 8,
   parameter bit  RIPPLE = 1'b1
) (
   input  alu_mode_e          mode,
   input  logic [MAG_W-1:0]   x,
   input  logic [MAG_W-1:0]   y,
   output logic [MAG_W-1:0]   sum,
   output logic               carry
);
   logic [MAG_W-1:0] lhs;
   logic [MAG_W-1:0] rhs;
   logic             cin;

   always_comb begin
      lhs = x;
      rhs = '0;
      cin = 1'b0;
      unique case (mode)
         ALU_SUM:  begin rhs = y;               end
         ALU_DIFF: begin rhs = ~y; cin = 1'b1;  end
         ALU_INV:  begin lhs = ~x;              end
         ALU_INC:  begin cin = 1'b1;            end
         default:  begin rhs = '0;              end
      endcase
   end

   generate
      if (RIPPLE) begin : g_ripple
         logic [MAG_W:0] cy;
         assign cy[0] = cin;
         for (genvar i = 0; i < MAG_W; i++) begin : g_bit
            assign sum[i]  = lhs[i] ^ rhs[i] ^ cy[i];
            assign cy[i+1] = (lhs[i] & rhs[i]) | (cy[i] & (lhs[i] ^ rhs[i]));
         end
         assign carry = cy[MAG_W];
      end else begin : g_behav
         logic [MAG_W:0] wide;
         assign wide  = {1'b0, lhs} + {1'b0, rhs} + {{MAG_W{1'b0}}, cin};
         assign sum   = wide[MAG_W-1:0];
         assign carry = wide[MAG_W];
      end
   endgenerate
endmodule

// File: rtl/sm_seq_ctrl.sv
module sm_seq_ctrl
   import sm_addsub_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start,
   input  logic      take_diff,
   input  logic      carry_e,
   output logic      ld_ops,
   output logic      ld_path,
   output logic      do_arith,
   output logic      do_fix,
   output logic      do_inc,
   output logic      busy,
   output logic      done,
   output alu_mode_e mode
);
   seq_state_e state_q, state_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   always_comb begin
      state_d  = state_q;
      ld_ops   = 1'b0;
      ld_path  = 1'b0;
      do_arith = 1'b0;
      do_fix   = 1'b0;
      do_inc   = 1'b0;
      done     = 1'b0;
      mode     = ALU_SUM;
      unique case (state_q)
         ST_IDLE: begin
            if (start) begin
               ld_ops  = 1'b1;
               state_d = ST_COMPARE;
            end
         end
         ST_COMPARE: begin
            ld_path = 1'b1;
            state_d = ST_ARITH;
         end
         ST_ARITH: begin
            do_arith = 1'b1;
            mode     = take_diff ? ALU_DIFF : ALU_SUM;
            state_d  = ST_CHECK;
         end
         ST_CHECK: begin
            do_fix  = 1'b1;
            mode    = ALU_INV;
            state_d = (take_diff && !carry_e) ? ST_INCR : ST_DONE;
         end
         ST_INCR: begin
            do_inc  = 1'b1;
            mode    = ALU_INC;
            state_d = ST_DONE;
         end
         ST_DONE: begin
            done    = 1'b1;
            state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/sm_addsub.sv
module sm_addsub
   import sm_addsub_pkg::*;
#(
   parameter int MAG_W  = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             op,
   input  logic             a_sign,
   input  logic [MAG_W-1:0] a_mag,
   input  logic             b_sign,
   input  logic [MAG_W-1:0] b_mag,
   output logic             done,
   output logic             res_sign,
   output logic [MAG_W-1:0] res_mag,
   output logic             ovf
);
   localparam logic [MAG_W-1:0] MAG_ZERO = '0;

   generate
      if (MAG_W < 2) begin : g_bad_width
         $error("sm_addsub: MAG_W must be at least 2");
      end
   endgenerate

   logic             as_q, bs_q, op_q, e_q, avf_q, path_sub_q;
   logic [MAG_W-1:0] acc_q, bm_q;
   logic             take_diff_d;
   logic             ld_ops, ld_path, do_arith, do_fix, do_inc, busy;
   alu_mode_e        mode;
   logic [MAG_W-1:0] alu_sum;
   logic             alu_carry;

   sm_sign_cmp u_cmp (
      .op        (op_q),
      .sign_x    (as_q),
      .sign_y    (bs_q),
      .take_diff (take_diff_d)
   );

   sm_mag_alu #(.MAG_W(MAG_W), .RIPPLE(RIPPLE)) u_alu (
      .mode  (mode),
      .x     (acc_q),
      .y     (bm_q),
      .sum   (alu_sum),
      .carry (alu_carry)
   );

   sm_seq_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .take_diff (path_sub_q),
      .carry_e   (e_q),
      .ld_ops    (ld_ops),
      .ld_path   (ld_path),
      .do_arith  (do_arith),
      .do_fix    (do_fix),
      .do_inc    (do_inc),
      .busy      (busy),
      .done      (done),
      .mode      (mode)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         as_q       <= 1'b0;
         bs_q       <= 1'b0;
         op_q       <= OP_ADD;
         acc_q      <= '0;
         bm_q       <= '0;
         e_q        <= 1'b0;
         avf_q      <= 1'b0;
         path_sub_q <= 1'b0;
      end else begin
         if (ld_ops) begin
            as_q  <= a_sign;
            acc_q <= a_mag;
            bs_q  <= b_sign;
            bm_q  <= b_mag;
            op_q  <= op;
         end
         if (ld_path) path_sub_q <= take_diff_d;
         if (do_arith) begin
            acc_q <= alu_sum;
            e_q   <= alu_carry;
            avf_q <= path_sub_q ? 1'b0 : alu_carry;
         end
         if (do_fix && path_sub_q) begin
            if (e_q) begin
               if (acc_q == MAG_ZERO) as_q <= 1'b0;
            end else begin
               acc_q <= alu_sum;
               as_q  <= ~as_q;
            end
         end
         if (do_inc) acc_q <= alu_sum;
      end
   end

   assign res_sign = as_q;
   assign res_mag  = acc_q;
   assign ovf      = avf_q;

endmodule

// File: rtl/sm_addsub_chk.sv
module sm_addsub_chk #(
   parameter int MAG_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             done,
   input logic             busy,
   input logic             path_sub,
   input logic             res_sign,
   input logic [MAG_W-1:0] res_mag,
   input logic             ovf
);
   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r4_no_ovf_on_diff: assert property (@(posedge clk) disable iff (!rst_n)
      (done && path_sub) |-> !ovf);

   a_r5_positive_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (done && path_sub && res_mag == '0) |-> !res_sign);

   a_r8_hold_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> ($stable(res_sign) && $stable(res_mag) && $stable(ovf)));

   a_r6_done_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);
endmodule

bind sm_addsub sm_addsub_chk #(.MAG_W(MAG_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .done     (done),
   .busy     (busy),
   .path_sub (path_sub_q),
   .res_sign (res_sign),
   .res_mag  (res_mag),
   .ovf      (ovf)
);

// File: tb/tb_sm_addsub.sv
module tb_sm_addsub;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         op = 1'b0;
   logic         a_sign = 1'b0, b_sign = 1'b0;
   logic [W-1:0] a_mag = '0, b_mag = '0;
   logic         done, res_sign, ovf;
   logic [W-1:0] res_mag;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   sm_addsub #(.MAG_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op),
      .a_sign(a_sign), .a_mag(a_mag), .b_sign(b_sign), .b_mag(b_mag),
      .done(done), .res_sign(res_sign), .res_mag(res_mag), .ovf(ovf)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // integer model of the rules
   task automatic model(input logic o, input logic sa, input int ma,
                        input logic sb, input int mb,
                        output int s, output int m, output int v, output int lat);
      int full;
      if ((sa ^ sb) == o) begin
         full = ma + mb;
         m = full % (1 << W);
         v = (full >= (1 << W)) ? 1 : 0;
         s = sa;
         lat = 4;
      end else begin
         v = 0;
         if (ma > mb)      begin m = ma - mb; s = sa;   lat = 4; end
         else if (ma < mb) begin m = mb - ma; s = !sa;  lat = 5; end
         else              begin m = 0;       s = 0;    lat = 4; end
      end
   endtask

   task automatic issue(input logic o, input logic sa, input int ma,
                        input logic sb, input int mb,
                        input int poke_at, output int lat);
      @(negedge clk);
      op = o; a_sign = sa; a_mag = ma[W-1:0]; b_sign = sb; b_mag = mb[W-1:0];
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      lat = 1;
      while (!done && lat < 40) begin
         if (lat == poke_at) begin
            start = 1'b1; op = ~o; a_mag = ~ma[W-1:0]; a_sign = ~sa;
         end
         @(posedge clk);
         @(negedge clk);
         start = 1'b0;
         lat++;
      end
      if (!done) begin
         errors++;
         $display("FAIL R6: actual no done expected done");
      end
   endtask

   task automatic run_op(input string req, input logic o, input logic sa, input int ma,
                         input logic sb, input int mb);
      int s, m, v, el, lat;
      model(o, sa, ma, sb, mb, s, m, v, el);
      issue(o, sa, ma, sb, mb, 0, lat);
      chk({req, " sign"}, int'(res_sign), s);
      chk({req, " mag"}, int'(res_mag), m);
      chk({req, " ovf"}, int'(ovf), v);
      chk("R6 latency", lat, el);
      @(posedge clk); @(negedge clk);
      chk("R6 done one cycle", int'(done), 0);
      chk("R8 hold mag", int'(res_mag), m);
   endtask

   task automatic t_reset();
      chk("R1 done", int'(done), 0);
      chk("R1 sign", int'(res_sign), 0);
      chk("R1 mag", int'(res_mag), 0);
      chk("R1 ovf", int'(ovf), 0);
   endtask

   task automatic t_sum_path();
      run_op("R2 add ++", 1'b0, 1'b0, 20, 1'b0, 35);
      run_op("R2 add --", 1'b0, 1'b1, 7, 1'b1, 9);
      run_op("R2 sub +-", 1'b1, 1'b0, 50, 1'b1, 60);
      run_op("R2 sub -+", 1'b1, 1'b1, 3, 1'b0, 4);
   endtask

   task automatic t_overflow();
      run_op("R3 carry", 1'b0, 1'b0, 200, 1'b0, 100);
      run_op("R3 exact top", 1'b0, 1'b1, 255, 1'b1, 1);
      run_op("R3 no carry", 1'b0, 1'b0, 128, 1'b0, 127);
   endtask

   task automatic t_diff_path();
      run_op("R4 add +- a>b", 1'b0, 1'b0, 90, 1'b1, 30);
      run_op("R5 add +- a<b", 1'b0, 1'b0, 30, 1'b1, 90);
      run_op("R5 sub ++ a<b", 1'b1, 1'b0, 0, 1'b0, 255);
      run_op("R5 sub -- a>b", 1'b1, 1'b1, 255, 1'b1, 0);
      run_op("R5 sub -- equal", 1'b1, 1'b1, 77, 1'b1, 77);
      run_op("R5 add -+ zeros", 1'b0, 1'b1, 0, 1'b0, 0);
   endtask

   task automatic t_busy_start();
      int s, m, v, el, lat;
      model(1'b1, 1'b0, 10, 1'b0, 40, s, m, v, el);
      issue(1'b1, 1'b0, 10, 1'b0, 40, 2, lat);
      chk("R7 sign", int'(res_sign), s);
      chk("R7 mag", int'(res_mag), m);
      chk("R7 latency", lat, el);
      for (int k = 0; k < 8; k++) begin
         @(posedge clk); @(negedge clk);
         if (done) chk("R7 no second done", 1, 0);
      end
      chk("R8 hold sign", int'(res_sign), s);
      chk("R8 hold mag idle", int'(res_mag), m);
   endtask

   task automatic t_random();
      logic [15:0] lf = 16'hACE1;
      for (int n = 0; n < 150; n++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         run_op(lf[0] ? "R4 rand" : "R2 rand", lf[1], lf[2], int'(lf[10:3]),
                lf[11], (lf[12] ? int'(lf[10:3]) : int'({lf[15:13], lf[4:0]})));
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_sum_path();
      t_overflow();
      t_diff_path();
      t_busy_start();
      t_random();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule